// File: doc/BRIEF.md
# Power-up Strap Capture and Pad Function Multiplexer

This block decides, once per reset, how the device's control port is wired, and then steers five pad slots. Two bidirectional pads double as straps. The mode pad selects between a 2-wire and a 3-wire serial control port. The chip-select pad supplies the 2-wire device address bit. Both are captured on the first rising clock edge after reset is released. The captured values hold until the next reset.

After capture, each pad is driven from its own mode field. Two output-only pads can drive a fixed level, a PLL clock or, on one of them, a clock at 256 times the converter sample rate. The mode pad and the detect pad are general-purpose pins. The detect pad also has a pull-resistor control for jack-insertion sensing. In 2-wire mode the chip-select pad is a general-purpose pin. In 3-wire mode it is locked as the serial latch input. In that mode, any non-zero code in its mode field blocks all control writes. The serial engine, the PLLs and the analog pad cells sit outside this block. They consume its strobes and pad controls.

Top module: `pad_strap_mux`

## Requirements
- R1: On the first rising clock edge after `rstN` goes high, the block captures `padIn[0]` as the interface strap (1 = 3-wire, 0 = 2-wire, shown on `busThreeWire`) and `padIn[2]` as the address strap. Later changes on these inputs have no effect until the next reset.
- R2: While `rstN` is low, and until that first capture edge, every bit of `padOe` and `padDo` is 0 and `busThreeWire` is 0.
- R3: `busAddrSel` equals the captured address strap in 2-wire mode and is 0 in 3-wire mode.
- R4: In 3-wire mode, chip-select pad slot 4 is never driven (`padOe[4]=0`) for any `csMode` code, `csLatch` follows `padIn[2]`, and `gpioIn[2]` is 0. In 2-wire mode `csLatch` is 0.
- R5: `ctrlWriteBlock` is 1 exactly when the block is in 3-wire mode and `csMode` is 01, 10 or 11. It is 0 for 00 and always 0 in 2-wire mode.
- R6: Bidirectional slots 2 (mode pad, `modePadMode`) and 3 (detect pad, `detMode`) decode 3-bit codes as follows:
  - 000: input, `padOe=0`.
  - 001: drive 0.
  - 010: drive 1.
  - 011 to 111: drive 0.
- R7: Output-only slots 0 (`out1Mode`) and 1 (`out2Mode`) always have `padOe=1` after capture. Their codes are:
  - 000 and 001: drive 0.
  - 010: drive 1.
  - 011: drive the slot's PLL clock (`pllClkA` on slot 0, `pllClkB` on slot 1).
  - 100: drive `fsClk256` on slot 1 and 0 on slot 0.
  - 101 to 111: drive 0.
- R8: In 2-wire mode, chip-select slot 4 decodes `csMode` as follows: 00 input, 01 drive 0, 10 drive 1, 11 drive 0.
- R9: `gpioIn` bit order is {chip-select, detect, mode}. After capture, each bit equals the matching `padIn` bit while that pad's output is disabled, and 0 otherwise.
- R10: `detPull` controls the detect-pad resistors: 01 turns on `padPullDn` only, 10 turns on `padPullUp` only, and 00 or 11 turns on neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| padIn | input | 3 | Pad input levels {chip-select, detect, mode} |
| out1Mode | input | 3 | Mode code for output-only slot 0 |
| out2Mode | input | 3 | Mode code for output-only slot 1 |
| modePadMode | input | 3 | Mode code for the mode/strap pad, slot 2 |
| detMode | input | 3 | Mode code for the detect pad, slot 3 |
| csMode | input | 2 | Mode code for the chip-select pad, slot 4 |
| detPull | input | 2 | Detect pad pull-resistor select |
| pllClkA | input | 1 | First PLL clock |
| pllClkB | input | 1 | Second PLL clock |
| fsClk256 | input | 1 | Clock at 256 times the sample rate |
| padOe | output | 5 | Output enable per slot |
| padDo | output | 5 | Output data per slot |
| padPullUp | output | 1 | Detect pad pull-up enable |
| padPullDn | output | 1 | Detect pad pull-down enable |
| gpioIn | output | 3 | Input values seen on released pads |
| busThreeWire | output | 1 | Captured interface mode, 1 = 3-wire |
| busAddrSel | output | 1 | 2-wire device address bit |
| csLatch | output | 1 | Latch strobe to the serial engine in 3-wire mode |
| ctrlWriteBlock | output | 1 | Blocks control-port writes |

## Verification
The assertions rely on two conditions about the inputs:
- `rstN` is released between clock edges.
- The mode and pull inputs are settled values, not glitching during the sampled edge.

The bench meets both conditions by changing every input on the falling edge and releasing reset there too. All pad, clock and configuration inputs are otherwise unconstrained. So the random loop draws them freely, and the strap values are set only around each reset. Stimulus also toggles the strap inputs after capture, to confirm that the captured mode does not follow them.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int NUM_PADS   = 5;
  localparam int WIDE_PADS  = 4;
  localparam int BIDIR_PADS = 3;
  localparam int MODE_W     = 3;
  localparam int CS_MODE_W  = 2;
  localparam int PULL_W     = 2;

  // pad slot indices
  localparam int PAD_OUT1 = 0;
  localparam int PAD_OUT2 = 1;
  localparam int PAD_MODE = 2;
  localparam int PAD_DET  = 3;
  localparam int PAD_CS   = 4;

  // bidirectional input indices
  localparam int IN_MODE = 0;
  localparam int IN_DET  = 1;
  localparam int IN_CS   = 2;

  // per wide-slot capabilities
  localparam logic [WIDE_PADS-1:0] OUT_ONLY_MASK = 4'b0011;
  localparam logic [WIDE_PADS-1:0] PLL_MASK      = 4'b0011;
  localparam logic [WIDE_PADS-1:0] PLL_B_MASK    = 4'b0010;
  localparam logic [WIDE_PADS-1:0] FS_MASK       = 4'b0010;

  localparam logic [MODE_W-1:0] M_INPUT = 3'b000;
  localparam logic [MODE_W-1:0] M_LOW   = 3'b001;
  localparam logic [MODE_W-1:0] M_HIGH  = 3'b010;
  localparam logic [MODE_W-1:0] M_PLL   = 3'b011;
  localparam logic [MODE_W-1:0] M_FS    = 3'b100;

  localparam logic [CS_MODE_W-1:0] CS_INPUT = 2'b00;
  localparam logic [CS_MODE_W-1:0] CS_HIGH  = 2'b10;

  localparam logic [PULL_W-1:0] PULL_DOWN = 2'b01;
  localparam logic [PULL_W-1:0] PULL_UP   = 2'b10;

  typedef struct packed {
    logic active;
    logic threeWire;
    logic addrSel;
  } strapCtl_t;
endpackage

// File: rtl/padmux_strap_ctrl.sv
module padmux_strap_ctrl
  import padmux_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeStrap,
  input  logic      addrStrap,
  output strapCtl_t ctl
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl <= '0;
    end else if (!ctl.active) begin
      ctl.active    <= 1'b1;
      ctl.threeWire <= modeStrap;
      ctl.addrSel   <= addrStrap;
    end
  end

  // R1: once captured, the straps stay captured until reset
  p_active_sticky_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |=> ctl.active);

  // R1: captured strap values never move after capture
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |=> ($stable(ctl.threeWire) && $stable(ctl.addrSel)));
endmodule

// File: rtl/padmux_datapath.sv
module padmux_datapath
  import padmux_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  strapCtl_t                         ctl,
  input  logic [BIDIR_PADS-1:0]             padIn,
  input  logic [WIDE_PADS-1:0][MODE_W-1:0]  wideMode,
  input  logic [CS_MODE_W-1:0]              csMode,
  input  logic [PULL_W-1:0]                 detPull,
  input  logic                              pllClkA,
  input  logic                              pllClkB,
  input  logic                              fsClk256,
  output logic [NUM_PADS-1:0]               padOe,
  output logic [NUM_PADS-1:0]               padDo,
  output logic                              padPullUp,
  output logic                              padPullDn,
  output logic [BIDIR_PADS-1:0]             gpioIn,
  output logic                              busThreeWire,
  output logic                              busAddrSel,
  output logic                              csLatch,
  output logic                              ctrlWriteBlock
);
  logic [WIDE_PADS-1:0] wideOe;
  logic [WIDE_PADS-1:0] wideDo;
  logic                 csOe;
  logic                 csDo;

  for (genvar g = 0; g < WIDE_PADS; g++) begin : g_wide
    localparam bit OUT_ONLY = OUT_ONLY_MASK[g];
    localparam bit HAS_PLL  = PLL_MASK[g];
    localparam bit USE_B    = PLL_B_MASK[g];
    localparam bit HAS_FS   = FS_MASK[g];
    logic slotOe;
    logic slotDo;
    logic pllSrc;

    assign pllSrc = USE_B ? pllClkB : pllClkA;

    always_comb begin
      slotOe = 1'b1;
      slotDo = 1'b0;
      case (wideMode[g])
        M_INPUT: slotOe = OUT_ONLY;
        M_LOW:   slotDo = 1'b0;
        M_HIGH:  slotDo = 1'b1;
        M_PLL:   slotDo = HAS_PLL & pllSrc;
        M_FS:    slotDo = HAS_FS & fsClk256;
        default: slotDo = 1'b0;
      endcase
      if (!ctl.active) begin
        slotOe = 1'b0;
        slotDo = 1'b0;
      end
    end

    assign wideOe[g] = slotOe;
    assign wideDo[g] = slotDo;
  end

  always_comb begin
    csOe = 1'b0;
    csDo = 1'b0;
    if (ctl.active && !ctl.threeWire) begin
      case (csMode)
        CS_INPUT: csOe = 1'b0;
        CS_HIGH:  begin csOe = 1'b1; csDo = 1'b1; end
        default:  csOe = 1'b1;
      endcase
    end
  end

  assign padOe = {csOe, wideOe};
  assign padDo = {csDo, wideDo};

  assign gpioIn[IN_MODE] = ctl.active & padIn[IN_MODE] & ~wideOe[PAD_MODE];
  assign gpioIn[IN_DET]  = ctl.active & padIn[IN_DET]  & ~wideOe[PAD_DET];
  assign gpioIn[IN_CS]   = ctl.active & ~ctl.threeWire & padIn[IN_CS] & ~csOe;

  assign busThreeWire   = ctl.threeWire;
  assign busAddrSel     = ctl.addrSel & ~ctl.threeWire;
  assign csLatch        = ctl.active & ctl.threeWire & padIn[IN_CS];
  assign ctrlWriteBlock = ctl.active & ctl.threeWire & (csMode != CS_INPUT);

  assign padPullUp = (detPull == PULL_UP);
  assign padPullDn = (detPull == PULL_DOWN);

  // R2: nothing drives before the straps are captured
  p_quiet_before_strap_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (padOe == '0 && padDo == '0));

  // R4: the latch pad stays an input in 3-wire mode
  p_cs_locked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && ctl.threeWire) |-> (!padOe[PAD_CS] && !gpioIn[IN_CS]));

  // R5: writes can only be blocked in 3-wire mode
  p_block_needs_3w_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWriteBlock |-> ctl.threeWire);

  // R7: output-only slots are always driven once active
  p_outonly_driven_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |-> (padOe[PAD_OUT1] && padOe[PAD_OUT2]));

  // R9: a driven pad never reports an input value
  p_gpio_released_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gpioIn & padOe[NUM_PADS-1:PAD_MODE]) == '0);

  // R10: the two pulls never fight
  p_pull_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(padPullUp && padPullDn));
endmodule

// File: rtl/pad_strap_mux.sv
module pad_strap_mux
  import padmux_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [BIDIR_PADS-1:0]  padIn,
  input  logic [MODE_W-1:0]      out1Mode,
  input  logic [MODE_W-1:0]      out2Mode,
  input  logic [MODE_W-1:0]      modePadMode,
  input  logic [MODE_W-1:0]      detMode,
  input  logic [CS_MODE_W-1:0]   csMode,
  input  logic [PULL_W-1:0]      detPull,
  input  logic                   pllClkA,
  input  logic                   pllClkB,
  input  logic                   fsClk256,
  output logic [NUM_PADS-1:0]    padOe,
  output logic [NUM_PADS-1:0]    padDo,
  output logic                   padPullUp,
  output logic                   padPullDn,
  output logic [BIDIR_PADS-1:0]  gpioIn,
  output logic                   busThreeWire,
  output logic                   busAddrSel,
  output logic                   csLatch,
  output logic                   ctrlWriteBlock
);
  strapCtl_t ctl;
  logic [WIDE_PADS-1:0][MODE_W-1:0] wideMode;

  assign wideMode = {detMode, modePadMode, out2Mode, out1Mode};

  padmux_strap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeStrap (padIn[IN_MODE]),
    .addrStrap (padIn[IN_CS]),
    .ctl       (ctl)
  );

  padmux_datapath u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .padIn          (padIn),
    .wideMode       (wideMode),
    .csMode         (csMode),
    .detPull        (detPull),
    .pllClkA        (pllClkA),
    .pllClkB        (pllClkB),
    .fsClk256       (fsClk256),
    .padOe          (padOe),
    .padDo          (padDo),
    .padPullUp      (padPullUp),
    .padPullDn      (padPullDn),
    .gpioIn         (gpioIn),
    .busThreeWire   (busThreeWire),
    .busAddrSel     (busAddrSel),
    .csLatch        (csLatch),
    .ctrlWriteBlock (ctrlWriteBlock)
  );
endmodule

// File: tb/pad_strap_mux_tb.sv
`timescale 1ns/1ps
module pad_strap_mux_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] padIn = '0;
  logic [2:0] out1Mode = '0, out2Mode = '0, modePadMode = '0, detMode = '0;
  logic [1:0] csMode = '0, detPull = '0;
  logic       pllClkA = 1'b0, pllClkB = 1'b0, fsClk256 = 1'b0;
  logic [4:0] padOe, padDo;
  logic       padPullUp, padPullDn;
  logic [2:0] gpioIn;
  logic       busThreeWire, busAddrSel, csLatch, ctrlWriteBlock;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit capTw = 1'b0;
  bit capAd = 1'b0;

  always #2.5 clk = ~clk;

  pad_strap_mux u_dut (
    .clk(clk), .rstN(rstN), .padIn(padIn),
    .out1Mode(out1Mode), .out2Mode(out2Mode), .modePadMode(modePadMode),
    .detMode(detMode), .csMode(csMode), .detPull(detPull),
    .pllClkA(pllClkA), .pllClkB(pllClkB), .fsClk256(fsClk256),
    .padOe(padOe), .padDo(padDo), .padPullUp(padPullUp), .padPullDn(padPullDn),
    .gpioIn(gpioIn), .busThreeWire(busThreeWire), .busAddrSel(busAddrSel),
    .csLatch(csLatch), .ctrlWriteBlock(ctrlWriteBlock)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6/R7 expected {oe,do} of a wide slot
  function automatic logic [1:0] expWide(input int slot, input logic [2:0] m);
    logic outOnly = (slot < 2);
    logic pll = (slot == 0) ? pllClkA : (slot == 1) ? pllClkB : 1'b0;
    case (m)
      3'b000:  return {outOnly, 1'b0};
      3'b010:  return 2'b11;
      3'b011:  return {1'b1, pll};
      3'b100:  return {1'b1, (slot == 1) ? fsClk256 : 1'b0};
      default: return 2'b10;
    endcase
  endfunction

  // R4/R8 expected {oe,do} of the chip-select slot
  function automatic logic [1:0] expCs(input logic tw, input logic [1:0] m);
    if (tw) return 2'b00;
    case (m)
      2'b00:   return 2'b00;
      2'b10:   return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic checkAll();
    logic [1:0] w0 = expWide(0, out1Mode);
    logic [1:0] w1 = expWide(1, out2Mode);
    logic [1:0] w2 = expWide(2, modePadMode);
    logic [1:0] w3 = expWide(3, detMode);
    logic [1:0] c  = expCs(capTw, csMode);
    logic [4:0] eOe = {c[1], w3[1], w2[1], w1[1], w0[1]};
    logic [4:0] eDo = {c[0], w3[0], w2[0], w1[0], w0[0]};
    logic [2:0] eG;
    eG[0] = padIn[0] & ~w2[1];
    eG[1] = padIn[1] & ~w3[1];
    eG[2] = ~capTw & padIn[2] & ~c[1];
    check("R7 out-only oe", {30'd0, padOe[1:0]}, {30'd0, eOe[1:0]});
    check("R7 out-only do", {30'd0, padDo[1:0]}, {30'd0, eDo[1:0]});
    check("R6 bidir oe", {30'd0, padOe[3:2]}, {30'd0, eOe[3:2]});
    check("R6 bidir do", {30'd0, padDo[3:2]}, {30'd0, eDo[3:2]});
    check(capTw ? "R4 cs oe 3w" : "R8 cs oe 2w", {31'd0, padOe[4]}, {31'd0, eOe[4]});
    check(capTw ? "R4 cs do 3w" : "R8 cs do 2w", {31'd0, padDo[4]}, {31'd0, eDo[4]});
    check("R9 gpioIn", {29'd0, gpioIn}, {29'd0, eG});
    check("R4 csLatch", {31'd0, csLatch}, {31'd0, capTw & padIn[2]});
    check("R5 write block", {31'd0, ctrlWriteBlock}, {31'd0, capTw & (csMode != 2'b00)});
    check("R10 pull up", {31'd0, padPullUp}, {31'd0, detPull == 2'b10});
    check("R10 pull down", {31'd0, padPullDn}, {31'd0, detPull == 2'b01});
    check("R1 mode held", {31'd0, busThreeWire}, {31'd0, capTw});
    check("R3 address", {31'd0, busAddrSel}, {31'd0, capAd & ~capTw});
  endtask

  task automatic randomize_inputs();
    padIn = 3'($urandom);
    out1Mode = 3'($urandom); out2Mode = 3'($urandom);
    modePadMode = 3'($urandom); detMode = 3'($urandom);
    csMode = 2'($urandom); detPull = 2'($urandom);
    pllClkA = 1'($urandom); pllClkB = 1'($urandom); fsClk256 = 1'($urandom);
  endtask

  task automatic doReset(input bit tw, input bit ad);
    @(negedge clk);
    rstN = 1'b0;
    randomize_inputs();
    padIn[0] = tw;
    padIn[2] = ad;
    #1;
    check("R2 oe in reset", {27'd0, padOe}, 32'd0);
    check("R2 do in reset", {27'd0, padDo}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R2 oe before capture", {27'd0, padOe}, 32'd0);
    check("R2 mode before capture", {31'd0, busThreeWire}, 32'd0);
    @(negedge clk);
    capTw = tw;
    capAd = ad;
    padIn[0] = ~tw;
    padIn[2] = ~ad;
    #1;
    check("R1 captured mode", {31'd0, busThreeWire}, {31'd0, tw});
    check("R3 captured address", {31'd0, busAddrSel}, {31'd0, ad & ~tw});
    repeat (3) @(negedge clk);
    #1;
    check("R1 strap ignored later", {31'd0, busThreeWire}, {31'd0, tw});
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2718));
    for (int s = 0; s < 4; s++) begin
      doReset(s[0], s[1]);
      // R5/R4/R8: every chip-select code in this interface mode
      for (int m = 0; m < 4; m++) begin
        @(negedge clk);
        csMode = 2'(m);
        padIn = 3'($urandom);
        #1;
        checkAll();
      end
      // R6/R7: every code on every wide slot
      for (int m = 0; m < 8; m++) begin
        @(negedge clk);
        out1Mode = 3'(m); out2Mode = 3'(m);
        modePadMode = 3'(m); detMode = 3'(m);
        pllClkA = 1'b1; pllClkB = 1'b0; fsClk256 = 1'b1;
        detPull = 2'(m);
        #1;
        checkAll();
        @(negedge clk);
        pllClkA = 1'b0; pllClkB = 1'b1; fsClk256 = 1'b0;
        #1;
        checkAll();
      end
      // constrained random mix
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        randomize_inputs();
        #1;
        checkAll();
      end
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule